// File: doc/BRIEF.md
# Supply-monitor reset controller

This block turns a supply comparator into a system reset. The comparator output may change at any time. It says whether the supply is above threshold. The block synchronizes it and shows it to software as a read-only status bit. When the monitor is both enabled and chosen as a reset source, the block holds the core in reset while the supply is low. Software reaches it through a two-register read/write port. One register holds the monitor enable and the status bit. The other holds the reset-source select bit and a flag that records a power-on or power-fail reset.

The monitor needs time to settle after it is switched on. A parameterized counter models that time. It starts when the enable goes from 0 to 1 and is cleared when the enable goes to 0. Choosing the monitor as a reset source while it is off or still settling is treated as an error and resets the system at once. A software-reset request also resets the core. Every reset is stretched to a minimum length. The power-on input reloads every register. All other reset causes leave the enable and select bits as they were.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: While `por_n` is low, `core_rst_no` is low. It stays low until STRETCH_CYC+2 clock edges after `por_n` rises. A power-on reset sets enable=1, select=0 and flag=1.
- R2: Address 0 is the monitor control register: bit 7 is the enable (read/write), bit 6 is the status (read-only), and bits 5..0 read 0 and ignore writes. Address 1 reads the select at bit 1 and the flag at bit 0, with all other bits 0. The flag cannot be written.
- R3: The status bit reads 1 when the comparator reports the supply above threshold and 0 when it is at or below threshold. It follows the input after two synchronizer flops.
- R4: If enable=1, select=1 and the synchronized supply is low, `core_rst_no` goes low by the third edge after the input falls. It stays low for as long as the supply stays low, and the flag is set to 1.
- R5: Once the supply returns above threshold, `core_rst_no` rises exactly STRETCH_CYC+2 edges after the input rises.
- R6: A low supply causes no reset when enable=0 or select=0.
- R7: Writing 1 to the select bit when enable=1 and SETTLE_CYC edges have passed since the enable rose sets the select bit and causes no reset.
- R8: Writing 1 to the select bit while the monitor is disabled or still settling pulls `core_rst_no` low at that edge. The select bit keeps its old value and the flag is cleared.
- R9: A one-cycle `swrst_req_i` pulls `core_rst_no` low for exactly STRETCH_CYC cycles. It leaves enable and select unchanged and clears the flag.
- R10: Every low period of `core_rst_no` lasts at least STRETCH_CYC cycles.
- R11: Clearing the enable restarts settling. After the enable is set again, a select write made before SETTLE_CYC edges have passed is treated as premature (R8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; asserts asynchronously and is released synchronously |
| cmp_above_i | input | 1 | Comparator output (1 = supply above threshold), asynchronous to `clk` |
| swrst_req_i | input | 1 | Software reset request, one cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 = monitor control, 1 = reset source |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the register at `reg_addr_i` (combinational) |
| core_rst_no | output | 1 | Core reset, active low |

## Verification
The bench tries to select the monitor as a reset source right after power-on, while the monitor is disabled, and again after it has been re-enabled but before the count has finished. A design that checked only the enable, or that did not restart the settling count, would accept the select silently and produce no reset. A brownout is followed through to its release, with the release edge counted exactly. This catches an off-by-one in the stretch counter or in the synchronizer depth. The bench also drops the supply with the monitor deselected and with it disabled, and sets the reserved bits. It checks that a software reset and a premature select clear the power-fail flag but keep the enable, since a design that reset the enable on every reset would differ there.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int unsigned REG_W = 8;
  localparam logic ADDR_MON_CTRL = 1'b0;
  localparam logic ADDR_RST_SRC  = 1'b1;
  localparam int unsigned CTRL_EN_BIT   = 7;
  localparam int unsigned CTRL_STAT_BIT = 6;
  localparam int unsigned SRC_SEL_BIT   = 1;
  localparam int unsigned SRC_FLAG_BIT  = 0;
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q <= RST_VAL;
        else         stage_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q <= {STAGES{RST_VAL}};
        else         stage_q <= {stage_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/supmon_settle.sv
module supmon_settle #(
  parameter int unsigned CYCLES = 64
) (
  input  logic clk,
  input  logic arst_n,
  input  logic en_i,
  output logic settled_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)              cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign settled_o = en_i && (cnt_q == LIMIT);
endmodule

// File: rtl/supmon_rst_stretch.sv
module supmon_rst_stretch #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic trig_i,
  output logic rst_no
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] hold_q, hold_d;
  logic          rst_n_q, rst_n_d;

  always_comb begin
    hold_d = hold_q;
    if (trig_i)            hold_d = LOAD;
    else if (hold_q != '0) hold_d = hold_q - 1'b1;
    rst_n_d = (hold_d == '0);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold_q  <= LOAD;
      rst_n_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      rst_n_q <= rst_n_d;
    end
  end

  assign rst_no = rst_n_q;
endmodule

// File: rtl/supmon_rst_ctrl.sv
module supmon_rst_ctrl
  import supmon_pkg::*;
#(
  parameter int unsigned SETTLE_CYC  = 64,
  parameter int unsigned STRETCH_CYC = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             cmp_above_i,
  input  logic             swrst_req_i,
  input  logic             reg_wr_i,
  input  logic             reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             core_rst_no
);
  logic arst_n;
  logic above_s;
  logic settled;
  logic en_q, en_d;
  logic sel_q, sel_d;
  logic pwrfail_q, pwrfail_d;
  logic wr_ctrl, wr_src, sel_req, mon_ready, early_sel, mon_fail, rst_trig;

  // power-on reset: asserted at once, released on the clock
  supmon_sync #(.STAGES(2), .RST_VAL(1'b0)) u_por_sync (
    .clk(clk), .arst_n(por_n), .d_i(1'b1), .q_o(arst_n)
  );

  supmon_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cmp_sync (
    .clk(clk), .arst_n(arst_n), .d_i(cmp_above_i), .q_o(above_s)
  );

  supmon_settle #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk(clk), .arst_n(arst_n), .en_i(en_q), .settled_o(settled)
  );

  assign wr_ctrl   = reg_wr_i && (reg_addr_i == ADDR_MON_CTRL);
  assign wr_src    = reg_wr_i && (reg_addr_i == ADDR_RST_SRC);
  assign sel_req   = wr_src && reg_wdata_i[SRC_SEL_BIT];
  assign mon_ready = en_q && settled;
  assign early_sel = sel_req && !mon_ready;
  assign mon_fail  = en_q && sel_q && !above_s;
  assign rst_trig  = mon_fail || early_sel || swrst_req_i;

  always_comb begin
    en_d      = en_q;
    sel_d     = sel_q;
    pwrfail_d = pwrfail_q;
    if (wr_ctrl)                en_d  = reg_wdata_i[CTRL_EN_BIT];
    if (wr_src && !early_sel)   sel_d = reg_wdata_i[SRC_SEL_BIT];
    if (mon_fail)                       pwrfail_d = 1'b1;
    else if (early_sel || swrst_req_i)  pwrfail_d = 1'b0;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      en_q      <= 1'b1;
      sel_q     <= 1'b0;
      pwrfail_q <= 1'b1;
    end else begin
      en_q      <= en_d;
      sel_q     <= sel_d;
      pwrfail_q <= pwrfail_d;
    end
  end

  supmon_rst_stretch #(.CYCLES(STRETCH_CYC)) u_stretch (
    .clk(clk), .arst_n(arst_n), .trig_i(rst_trig), .rst_no(core_rst_no)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_MON_CTRL) begin
      reg_rdata_o[CTRL_EN_BIT]   = en_q;
      reg_rdata_o[CTRL_STAT_BIT] = above_s;
    end else begin
      reg_rdata_o[SRC_SEL_BIT]  = sel_q;
      reg_rdata_o[SRC_FLAG_BIT] = pwrfail_q;
    end
  end
endmodule

// File: rtl/supmon_rst_ctrl_chk.sv
module supmon_rst_ctrl_chk #(
  parameter int unsigned STRETCH_CYC = 8
) (
  input logic       clk,
  input logic       arst_n,
  input logic       en_q,
  input logic       sel_q,
  input logic       above_s,
  input logic       settled,
  input logic       pwrfail_q,
  input logic       swrst_req_i,
  input logic       reg_wr_i,
  input logic       reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       core_rst_no
);
  localparam int unsigned LW = $clog2(STRETCH_CYC + 1) + 1;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                        low_cnt <= '0;
    else if (core_rst_no)               low_cnt <= '0;
    else if (low_cnt != {LW{1'b1}})     low_cnt <= low_cnt + 1'b1;
  end

  // R4
  mon_fail_rst_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (en_q && sel_q && !above_s) |=> (!core_rst_no && pwrfail_q));

  // R8
  early_sel_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (reg_wr_i && reg_addr_i && reg_wdata_i[1] && !(en_q && settled) &&
     !(en_q && sel_q && !above_s))
    |=> (!core_rst_no && $stable(sel_q) && !pwrfail_q));

  // R9
  swrst_keep_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (swrst_req_i && !reg_wr_i && !(en_q && sel_q && !above_s))
    |=> (!core_rst_no && !pwrfail_q && $stable(en_q) && $stable(sel_q)));

  // R10
  min_low_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(core_rst_no) |-> (low_cnt >= LW'(STRETCH_CYC)));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !reg_addr_i |-> (reg_rdata_o[5:0] == 6'd0));
endmodule

bind supmon_rst_ctrl supmon_rst_ctrl_chk #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
  .clk(clk), .arst_n(arst_n), .en_q(en_q), .sel_q(sel_q), .above_s(above_s),
  .settled(settled), .pwrfail_q(pwrfail_q), .swrst_req_i(swrst_req_i),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .core_rst_no(core_rst_no)
);

// File: tb/supmon_rst_ctrl_tb.sv
`timescale 1ns/1ps
module supmon_rst_ctrl_tb_top;
  localparam int S = 8;   // stretch cycles (design default)
  localparam int T = 64;  // settle cycles (design default)

  logic clk = 1'b0;
  logic por_n, cmp_above_i, swrst_req_i, reg_wr_i, reg_addr_i;
  logic [7:0] reg_wdata_i, reg_rdata_o;
  logic core_rst_no;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  supmon_rst_ctrl dut_i (
    .clk(clk), .por_n(por_n), .cmp_above_i(cmp_above_i), .swrst_req_i(swrst_req_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .core_rst_no(core_rst_no)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    reg_addr_i = a;
    #0.1;
    d = reg_rdata_o;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = 8'h00;
  endtask

  task automatic t_por();
    logic [7:0] d;
    por_n = 1'b0;
    cyc(3);
    chk("R1 rst during por", {7'd0, core_rst_no}, 8'h00);
    rd(1'b0, d); chk("R1 enable after por", {7'd0, d[7]}, 8'h01);
    rd(1'b1, d); chk("R1 src after por", d, 8'h01);
    por_n = 1'b1;
    cyc(S + 1);
    chk("R1 rst held", {7'd0, core_rst_no}, 8'h00);
    cyc(1);
    chk("R1 rst released", {7'd0, core_rst_no}, 8'h01);
    cyc(2);
    rd(1'b0, d); chk("R3 status above", d, 8'hC0);
  endtask

  task automatic t_premature();
    logic [7:0] d;
    wr(1'b1, 8'h02);
    chk("R8 early select resets", {7'd0, core_rst_no}, 8'h00);
    rd(1'b1, d); chk("R8 select kept, flag cleared", d, 8'h00);
    cyc(S + 1);
    chk("R9/R10 stretch after early select", {7'd0, core_rst_no}, 8'h01);
  endtask

  task automatic t_select_ok();
    logic [7:0] d;
    cyc(T + 4);
    wr(1'b1, 8'h02);
    cyc(3);
    chk("R7 no reset on settled select", {7'd0, core_rst_no}, 8'h01);
    rd(1'b1, d); chk("R7 select set", d, 8'h02);
  endtask

  task automatic t_brownout();
    logic [7:0] d;
    @(negedge clk); cmp_above_i = 1'b0;
    cyc(2);
    chk("R4 not yet at 2 edges", {7'd0, core_rst_no}, 8'h01);
    rd(1'b0, d); chk("R3 status low", d, 8'h80);
    cyc(1);
    chk("R4 reset at 3rd edge", {7'd0, core_rst_no}, 8'h00);
    cyc(20);
    chk("R4 held while low", {7'd0, core_rst_no}, 8'h00);
    rd(1'b1, d); chk("R4 flag set", d, 8'h03);
    cmp_above_i = 1'b1;
    cyc(S + 1);
    chk("R5 still low", {7'd0, core_rst_no}, 8'h00);
    cyc(1);
    chk("R5 released", {7'd0, core_rst_no}, 8'h01);
  endtask

  task automatic t_swrst();
    logic [7:0] d;
    @(negedge clk); swrst_req_i = 1'b1;
    @(negedge clk); swrst_req_i = 1'b0;
    chk("R9 swrst asserts", {7'd0, core_rst_no}, 8'h00);
    cyc(S - 1);
    chk("R9 swrst held", {7'd0, core_rst_no}, 8'h00);
    cyc(1);
    chk("R9 swrst released", {7'd0, core_rst_no}, 8'h01);
    rd(1'b0, d); chk("R9 enable kept", d, 8'hC0);
    rd(1'b1, d); chk("R9 flag cleared, select kept", d, 8'h02);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    wr(1'b0, 8'hBF);
    rd(1'b0, d); chk("R2 reserved and status", d, 8'hC0);
    wr(1'b1, 8'hFD);
    rd(1'b1, d); chk("R2 flag not writable", d, 8'h00);
  endtask

  task automatic t_not_selected();
    logic [7:0] d;
    @(negedge clk); cmp_above_i = 1'b0;
    cyc(6);
    chk("R6 deselected no reset", {7'd0, core_rst_no}, 8'h01);
    rd(1'b1, d); chk("R6 flag unchanged", d, 8'h00);
    cmp_above_i = 1'b1;
    cyc(3);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    wr(1'b1, 8'h02);
    wr(1'b0, 8'h00);
    @(negedge clk); cmp_above_i = 1'b0;
    cyc(6);
    chk("R6 disabled no reset", {7'd0, core_rst_no}, 8'h01);
    rd(1'b0, d); chk("R2 enable cleared", d, 8'h00);
    cmp_above_i = 1'b1;
    cyc(3);
    wr(1'b1, 8'h02);
    chk("R8 select while disabled resets", {7'd0, core_rst_no}, 8'h00);
    cyc(S + 1);
  endtask

  task automatic t_resettle();
    logic [7:0] d;
    wr(1'b0, 8'h80);
    cyc(T - 4);
    wr(1'b1, 8'h02);
    chk("R11 select before resettle resets", {7'd0, core_rst_no}, 8'h00);
    cyc(S + 12);
    wr(1'b1, 8'h02);
    cyc(2);
    chk("R11 select after resettle ok", {7'd0, core_rst_no}, 8'h01);
  endtask

  task automatic t_por2();
    logic [7:0] d;
    wr(1'b0, 8'h00);
    @(negedge clk); por_n = 1'b0;
    cyc(2);
    rd(1'b0, d); chk("R1 por sets enable", {7'd0, d[7]}, 8'h01);
    rd(1'b1, d); chk("R1 por resets select, sets flag", d, 8'h01);
    por_n = 1'b1;
    cyc(S + 4);
  endtask

  initial begin
    por_n = 1'b0; cmp_above_i = 1'b1; swrst_req_i = 1'b0;
    reg_wr_i = 1'b0; reg_addr_i = 1'b0; reg_wdata_i = 8'h00;
    t_por();
    t_premature();
    t_select_ok();
    t_brownout();
    t_swrst();
    t_reserved();
    t_not_selected();
    t_disabled();
    t_resettle();
    t_por2();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule